// File: doc/BRIEF.md
# Programmable Frequency Ratio Register Controller

This block holds the programmed multiplier settings for two synthesized clock channels: a processor clock channel and a serial reference channel. Software writes divider values and mode bits over a simple word-write bus grouped into transactions. The block turns the resulting state into a multiply/divide pair for a frequency synthesizer. While a channel runs from its table setting, the pair is gear × table N over table M. Once software switches the channel to programmed mode, the pair is gear × programmed N over programmed M.

The processor channel has its own programmable N (9 bits) and M (7 bits). The reference channel has only a programmable N. Its M is a fixed value supplied by the frequency-select logic, and it uses that value in both modes.

Beats of a transaction are staged and applied together on the beat marked last. The block enforces the update rules. M moves only together with N. N must lie inside a configured window. Programmed mode cannot be entered with a zero term. Every accepted change of an active N or M is announced on a one-cycle strobe per channel, for use by a glide controller downstream.

Top module: `pfreq_ctrl`

## Requirements
- R1: After reset both channels are in table mode, all programmed N and M values are zero, both error flags are low, the change strobes are low, and the outputs show gear × table N and table M (reference channel: gear × reference table N and the fixed reference M).
- R2: Beats without `wr_last` change no output. All beats of a transaction take effect together at the clock edge that accepts the beat with `wr_last` high. The new values are visible in the cycle after that edge.
- R3: The write address map is as follows. Address 0 is the processor N (data[8:0]). Address 1 is the processor M (data[6:0]). Address 2 is the reference N (data[8:0]). Address 3 is the mode word: data[0] is processor programmed mode and data[1] is reference programmed mode. A write to any other address has no effect.
- R4: In programmed mode a channel outputs `*_mul` = gear × active N and `*_div` = active M. The reference channel's M is always `ref_fix_m`. In table mode the channel outputs the table pair.
- R5: A transaction that writes the processor M without the processor N leaves the active M unchanged. A transaction that writes both applies both.
- R6: A transaction may update N alone. The active M then keeps its value.
- R7: A written N below N_MIN (16) or above N_MAX (480) rejects that channel's whole update (N, M and mode), and sets `err_range`.
- R8: If an update would leave a channel in programmed mode with a zero N or a zero M, that channel's whole update is rejected and `err_zero` is set.
- R9: Both error flags stay high until reset.
- R10: `chg[0]` (processor) and `chg[1]` (reference) are high for exactly the one cycle after an accepted update changes that channel's active N or M. A mode-only change, a rejected update, or a rewrite of the same values gives no pulse.
- R11: The channels are checked independently. A rejected update on one channel does not block an accepted update on the other channel in the same transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write beat valid |
| wr_last | input | 1 | Beat closes the transaction |
| wr_addr | input | 3 | Register address |
| wr_data | input | 9 | Write data |
| gear | input | 8 | Gear constant from frequency select |
| cpu_tbl_n | input | 9 | Processor table N |
| cpu_tbl_m | input | 7 | Processor table M |
| ref_tbl_n | input | 9 | Reference table N |
| ref_fix_m | input | 7 | Fixed reference M |
| cpu_mul | output | 17 | Processor multiply term |
| cpu_div | output | 7 | Processor divide term |
| ref_mul | output | 17 | Reference multiply term |
| ref_div | output | 7 | Reference divide term |
| chg | output | 2 | Change strobes {reference, processor} |
| err_range | output | 1 | Sticky N-window error |
| err_zero | output | 1 | Sticky zero-term enable error |

## Verification
A corrupted active register reaches the ports in the very next cycle whenever its channel is in programmed mode. The multiply or divide output takes the wrong value, and a wrong strobe pattern appears on `chg`. A corrupted register stays hidden while the channel is in table mode. For that reason the vector walk preloads values in table mode and then switches modes, so that stale or partially applied state shows up one cycle after the enabling transaction. A shadow register that is not cleared after a commit shows up as a spurious M or mode change on a later single-beat transaction.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 9;
    localparam int N_W    = 9;
    localparam int M_W    = 7;
    localparam int G_W    = 8;
    localparam int MUL_W  = G_W + N_W;
    localparam int NCH    = 2;
    localparam int CH_CPU = 0;
    localparam int CH_REF = 1;

    localparam logic [ADDR_W-1:0] A_CPU_N = 3'd0;
    localparam logic [ADDR_W-1:0] A_CPU_M = 3'd1;
    localparam logic [ADDR_W-1:0] A_REF_N = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd3;

    // staged view of one channel inside an open transaction
    typedef struct packed {
        logic [N_W-1:0] n;
        logic           n_wr;
        logic [M_W-1:0] m;
        logic           m_wr;
        logic           en;
        logic           en_wr;
    } stage_t;

    function automatic stage_t apply_beat(stage_t s, int ch,
                                          logic [ADDR_W-1:0] a,
                                          logic [DATA_W-1:0] d);
        stage_t r;
        r = s;
        if (a == A_MODE) begin
            r.en    = d[ch];
            r.en_wr = 1'b1;
        end
        if (ch == CH_CPU) begin
            if (a == A_CPU_N) begin
                r.n    = d[N_W-1:0];
                r.n_wr = 1'b1;
            end
            if (a == A_CPU_M) begin
                r.m    = d[M_W-1:0];
                r.m_wr = 1'b1;
            end
        end else begin
            if (a == A_REF_N) begin
                r.n    = d[N_W-1:0];
                r.n_wr = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pfc_shadow.sv
module pfc_shadow
    import pfc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic                  wr_last,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output stage_t [NCH-1:0]      stg,
    output logic                  commit
);
    stage_t [NCH-1:0] sh_q;
    stage_t [NCH-1:0] sh_d;

    for (genvar c = 0; c < NCH; c++) begin : g_merge
        always_comb begin
            sh_d[c] = wr_valid ? apply_beat(sh_q[c], c, wr_addr, wr_data) : sh_q[c];
        end
    end

    assign commit = wr_valid & wr_last;
    assign stg    = sh_d;

    always_ff @(posedge clk) begin
        if (rst || commit) sh_q <= '0;
        else               sh_q <= sh_d;
    end

    // R2: once a transaction closes, nothing from it lingers in the stage
    assert_stage_flushed_R2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (sh_q[CH_CPU].n_wr == 1'b0 && sh_q[CH_CPU].m_wr == 1'b0 &&
                    sh_q[CH_REF].n_wr == 1'b0 && sh_q[CH_REF].en_wr == 1'b0));
endmodule

// File: rtl/pfc_ratio.sv
module pfc_ratio
    import pfc_pkg::*;
(
    input  logic [G_W-1:0]   gear,
    input  logic             prog,
    input  logic [N_W-1:0]   prog_n,
    input  logic [M_W-1:0]   prog_m,
    input  logic [N_W-1:0]   tbl_n,
    input  logic [M_W-1:0]   tbl_m,
    output logic [MUL_W-1:0] mul,
    output logic [M_W-1:0]   div
);
    logic [N_W-1:0] n_sel;

    always_comb begin
        n_sel = prog ? prog_n : tbl_n;
        div   = prog ? prog_m : tbl_m;
        mul   = MUL_W'(gear) * MUL_W'(n_sel);
    end
endmodule

// File: rtl/pfc_chan.sv
module pfc_chan
    import pfc_pkg::*;
#(
    parameter bit HAS_M = 1'b1,
    parameter int N_MIN = 16,
    parameter int N_MAX = 480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  stage_t           stg,
    input  logic [G_W-1:0]   gear,
    input  logic [N_W-1:0]   tbl_n,
    input  logic [M_W-1:0]   tbl_m,
    output logic [MUL_W-1:0] mul,
    output logic [M_W-1:0]   div,
    output logic             chg,
    output logic             err_range,
    output logic             err_zero
);
    localparam logic [N_W-1:0] N_LO = N_W'(N_MIN);
    localparam logic [N_W-1:0] N_HI = N_W'(N_MAX);

    logic [N_W-1:0] act_n;
    logic [M_W-1:0] act_m;
    logic           act_en;

    logic [N_W-1:0] cand_n;
    logic [M_W-1:0] cand_m;
    logic           cand_en;
    logic           n_in_win;
    logic           pair_ok;
    logic           accept;
    logic           moved;

    always_comb begin
        n_in_win = !stg.n_wr || (stg.n >= N_LO && stg.n <= N_HI);
        cand_n   = stg.n_wr ? stg.n : act_n;
        cand_m   = (stg.n_wr && stg.m_wr) ? stg.m : act_m;
        cand_en  = stg.en_wr ? stg.en : act_en;
        pair_ok  = (cand_n != '0) && (cand_m != '0);
        accept   = n_in_win && (!cand_en || pair_ok);
        moved    = (cand_n != act_n) || (cand_m != act_m);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_n     <= '0;
            act_en    <= 1'b0;
            chg       <= 1'b0;
            err_range <= 1'b0;
            err_zero  <= 1'b0;
        end else begin
            chg <= commit && accept && moved;
            if (commit) begin
                if (accept) begin
                    act_n  <= cand_n;
                    act_en <= cand_en;
                end
                if (!n_in_win)                        err_range <= 1'b1;
                if (n_in_win && cand_en && !pair_ok)  err_zero  <= 1'b1;
            end
        end
    end

    if (HAS_M) begin : g_prog_m
        always_ff @(posedge clk) begin
            if (rst)                  act_m <= '0;
            else if (commit && accept) act_m <= cand_m;
        end
    end else begin : g_fixed_m
        assign act_m = tbl_m;
    end

    pfc_ratio u_ratio (
        .gear   (gear),
        .prog   (act_en),
        .prog_n (act_n),
        .prog_m (act_m),
        .tbl_n  (tbl_n),
        .tbl_m  (tbl_m),
        .mul    (mul),
        .div    (div)
    );

    assert_hold_between_commits_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(act_n) && $stable(act_en)));

    assert_m_needs_n_R5: assert property (@(posedge clk) disable iff (rst)
        (HAS_M && commit && stg.m_wr && !stg.n_wr) |=> $stable(act_m));

    assert_n_window_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && stg.n_wr && (stg.n < N_LO || stg.n > N_HI)) |=> ($stable(act_n) && err_range));

    assert_prog_pair_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        act_en |-> (act_n != '0 && (!HAS_M || act_m != '0)));

    assert_range_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_range |=> err_range);

    assert_zero_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_zero |=> err_zero);

    assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (rst)
        chg |-> $past(commit));
endmodule

// File: rtl/pfreq_ctrl.sv
module pfreq_ctrl
    import pfc_pkg::*;
#(
    parameter int N_MIN = 16,
    parameter int N_MAX = 480
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_valid,
    input  logic                  wr_last,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [G_W-1:0]        gear,
    input  logic [N_W-1:0]        cpu_tbl_n,
    input  logic [M_W-1:0]        cpu_tbl_m,
    input  logic [N_W-1:0]        ref_tbl_n,
    input  logic [M_W-1:0]        ref_fix_m,
    output logic [MUL_W-1:0]      cpu_mul,
    output logic [M_W-1:0]        cpu_div,
    output logic [MUL_W-1:0]      ref_mul,
    output logic [M_W-1:0]        ref_div,
    output logic [NCH-1:0]        chg,
    output logic                  err_range,
    output logic                  err_zero
);
    stage_t [NCH-1:0]          stg;
    logic                      commit;
    logic [NCH-1:0][N_W-1:0]   tbl_n;
    logic [NCH-1:0][M_W-1:0]   tbl_m;
    logic [NCH-1:0][MUL_W-1:0] mul;
    logic [NCH-1:0][M_W-1:0]   div;
    logic [NCH-1:0]            e_rng;
    logic [NCH-1:0]            e_zero;

    assign tbl_n[CH_CPU] = cpu_tbl_n;
    assign tbl_m[CH_CPU] = cpu_tbl_m;
    assign tbl_n[CH_REF] = ref_tbl_n;
    assign tbl_m[CH_REF] = ref_fix_m;

    pfc_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_last  (wr_last),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stg      (stg),
        .commit   (commit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pfc_chan #(
            .HAS_M (c == CH_CPU),
            .N_MIN (N_MIN),
            .N_MAX (N_MAX)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .commit    (commit),
            .stg       (stg[c]),
            .gear      (gear),
            .tbl_n     (tbl_n[c]),
            .tbl_m     (tbl_m[c]),
            .mul       (mul[c]),
            .div       (div[c]),
            .chg       (chg[c]),
            .err_range (e_rng[c]),
            .err_zero  (e_zero[c])
        );
    end

    assign cpu_mul   = mul[CH_CPU];
    assign cpu_div   = div[CH_CPU];
    assign ref_mul   = mul[CH_REF];
    assign ref_div   = div[CH_REF];
    assign err_range = |e_rng;
    assign err_zero  = |e_zero;
endmodule

// File: tb/pfreq_ctrl_bench.sv
module pfreq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid, wr_last;
    logic [2:0]  wr_addr;
    logic [8:0]  wr_data;
    logic [7:0]  gear;
    logic [8:0]  cpu_tbl_n, ref_tbl_n;
    logic [6:0]  cpu_tbl_m, ref_fix_m;
    logic [16:0] cpu_mul, ref_mul;
    logic [6:0]  cpu_div, ref_div;
    logic [1:0]  chg;
    logic        err_range, err_zero;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pfreq_ctrl u_pfreq_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_last(wr_last),
        .wr_addr(wr_addr), .wr_data(wr_data), .gear(gear),
        .cpu_tbl_n(cpu_tbl_n), .cpu_tbl_m(cpu_tbl_m),
        .ref_tbl_n(ref_tbl_n), .ref_fix_m(ref_fix_m),
        .cpu_mul(cpu_mul), .cpu_div(cpu_div), .ref_mul(ref_mul), .ref_div(ref_div),
        .chg(chg), .err_range(err_range), .err_zero(err_zero)
    );

    typedef struct packed {
        logic [1:0]  nb;
        logic [2:0]  a0;
        logic [8:0]  d0;
        logic [2:0]  a1;
        logic [8:0]  d1;
        logic [16:0] cm;
        logic [6:0]  cd;
        logic [16:0] rm;
        logic [6:0]  rd;
        logic [1:0]  ch;
        logic        ez;
        logic        er;
    } vec_t;

    // gear 10, processor table 100/5, reference table N 50, fixed reference M 4
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R6 R10: preload processor N and M in table mode
        '{2'd2, 3'd0, 9'd200, 3'd1, 9'd8,  17'd1000, 7'd5, 17'd500, 7'd4, 2'b01, 1'b0, 1'b0},
        // R4 R10: enter programmed mode, no strobe for a mode-only change
        '{2'd1, 3'd3, 9'd1,   3'd0, 9'd0,  17'd2000, 7'd8, 17'd500, 7'd4, 2'b00, 1'b0, 1'b0},
        // R5: M written alone is ignored
        '{2'd1, 3'd1, 9'd3,   3'd0, 9'd0,  17'd2000, 7'd8, 17'd500, 7'd4, 2'b00, 1'b0, 1'b0},
        // R6: N written alone
        '{2'd1, 3'd0, 9'd300, 3'd0, 9'd0,  17'd3000, 7'd8, 17'd500, 7'd4, 2'b01, 1'b0, 1'b0},
        // R5: N and M together
        '{2'd2, 3'd0, 9'd100, 3'd1, 9'd2,  17'd1000, 7'd2, 17'd500, 7'd4, 2'b01, 1'b0, 1'b0},
        // R3 R10: reference N preload while in table mode
        '{2'd1, 3'd2, 9'd60,  3'd0, 9'd0,  17'd1000, 7'd2, 17'd500, 7'd4, 2'b10, 1'b0, 1'b0},
        // R4: reference programmed, uses fixed M
        '{2'd1, 3'd3, 9'd3,   3'd0, 9'd0,  17'd1000, 7'd2, 17'd600, 7'd4, 2'b00, 1'b0, 1'b0},
        // R7: N above the window is rejected
        '{2'd1, 3'd0, 9'd500, 3'd0, 9'd0,  17'd1000, 7'd2, 17'd600, 7'd4, 2'b00, 1'b0, 1'b1},
        // R11 R9: reference rejected, processor accepted in one transaction
        '{2'd2, 3'd2, 9'd8,   3'd0, 9'd40, 17'd400,  7'd2, 17'd600, 7'd4, 2'b01, 1'b0, 1'b1},
        // R7: lower window edge accepted
        '{2'd1, 3'd0, 9'd16,  3'd0, 9'd0,  17'd160,  7'd2, 17'd600, 7'd4, 2'b01, 1'b0, 1'b1},
        // R7: upper window edge accepted
        '{2'd1, 3'd0, 9'd480, 3'd0, 9'd0,  17'd4800, 7'd2, 17'd600, 7'd4, 2'b01, 1'b0, 1'b1},
        // R4: back to table mode on both channels
        '{2'd1, 3'd3, 9'd0,   3'd0, 9'd0,  17'd1000, 7'd5, 17'd500, 7'd4, 2'b00, 1'b0, 1'b1},
        // R10: M cleared to zero with same N in table mode, strobe for M change
        '{2'd2, 3'd0, 9'd480, 3'd1, 9'd0,  17'd1000, 7'd5, 17'd500, 7'd4, 2'b01, 1'b0, 1'b1},
        // R8: programmed mode with M zero is rejected
        '{2'd1, 3'd3, 9'd1,   3'd0, 9'd0,  17'd1000, 7'd5, 17'd500, 7'd4, 2'b00, 1'b1, 1'b1},
        // R10: rewrite of the same N gives no strobe
        '{2'd1, 3'd0, 9'd480, 3'd0, 9'd0,  17'd1000, 7'd5, 17'd500, 7'd4, 2'b00, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic beat(input logic [2:0] a, input logic [8:0] d, input logic last);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        wr_last  = last;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic check_outs(input string tag, input int cm, input int cd,
                              input int rm, input int rd);
        check({tag, " cpu_mul"}, int'(cpu_mul), cm);
        check({tag, " cpu_div"}, int'(cpu_div), cd);
        check({tag, " ref_mul"}, int'(ref_mul), rm);
        check({tag, " ref_div"}, int'(ref_div), rd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_last = 1'b0; wr_addr = '0; wr_data = '0;
        gear = 8'd10; cpu_tbl_n = 9'd100; cpu_tbl_m = 7'd5;
        ref_tbl_n = 9'd50; ref_fix_m = 7'd4;
        do_reset();

        // R1: reset state
        check_outs("R1 reset", 1000, 5, 500, 4);
        check("R1 reset chg", int'(chg), 0);
        check("R1 reset err_range", int'(err_range), 0);
        check("R1 reset err_zero", int'(err_zero), 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].nb == 2'd2) begin
                beat(VEC[i].a0, VEC[i].d0, 1'b0);
                beat(VEC[i].a1, VEC[i].d1, 1'b1);
            end else begin
                beat(VEC[i].a0, VEC[i].d0, 1'b1);
            end
            check_outs($sformatf("vector %0d", i), int'(VEC[i].cm), int'(VEC[i].cd),
                       int'(VEC[i].rm), int'(VEC[i].rd));
            check($sformatf("vector %0d chg", i), int'(chg), int'(VEC[i].ch));
            check($sformatf("vector %0d err_zero", i), int'(err_zero), int'(VEC[i].ez));
            check($sformatf("vector %0d err_range", i), int'(err_range), int'(VEC[i].er));
        end

        // R1: reset clears errors and programmed state
        do_reset();
        check_outs("R1 second reset", 1000, 5, 500, 4);
        check("R1 second reset err_range", int'(err_range), 0);
        check("R1 second reset err_zero", int'(err_zero), 0);

        // R2: staged beats are invisible until the last beat
        beat(3'd0, 9'd50, 1'b0);
        check_outs("R2 after beat one", 1000, 5, 500, 4);
        check("R2 after beat one chg", int'(chg), 0);
        beat(3'd1, 9'd7, 1'b0);
        check_outs("R2 after beat two", 1000, 5, 500, 4);
        beat(3'd3, 9'd1, 1'b1);
        check_outs("R2 commit applies all", 500, 7, 500, 4);
        check("R10 strobe on commit", int'(chg), 1);
        check("R8 valid enable no error", int'(err_zero), 0);
        @(negedge clk);
        check("R10 strobe lasts one cycle", int'(chg), 0);

        // R4: programmed output tracks gear
        gear = 8'd3;
        #1;
        check("R4 gear follow cpu_mul", int'(cpu_mul), 150);
        gear = 8'd10;

        // R8: reference programmed mode with N still zero
        beat(3'd3, 9'd2, 1'b1);
        check_outs("R8 reference zero N rejected", 1000, 5, 500, 4);
        check("R8 err_zero set", int'(err_zero), 1);
        check("R8 err_range clear", int'(err_range), 0);

        // R3: unmapped addresses are ignored
        beat(3'd5, 9'h1FF, 1'b1);
        check_outs("R3 address 5 ignored", 1000, 5, 500, 4);
        check("R3 address 5 chg", int'(chg), 0);
        beat(3'd7, 9'h1FF, 1'b1);
        check_outs("R3 address 7 ignored", 1000, 5, 500, 4);
        check("R3 address 7 chg", int'(chg), 0);

        // R9: error flag holds over idle cycles
        repeat (5) @(negedge clk);
        check("R9 err_zero sticky", int'(err_zero), 1);

        // R7: lower window violation (N=15)
        beat(3'd0, 9'd15, 1'b1);
        check("R7 below window err_range", int'(err_range), 1);
        check("R7 below window chg", int'(chg), 0);

        finish_run();
    end
endmodule